// File: doc/BRIEF.md
# Invalidation Queue Command Engine

This block runs the command ring of an address-translation unit's invalidation path. Software lays out 16-byte commands in a circular ring in memory. It programs the ring's 4 KB-aligned base and a size code through a queue-address register, then moves a tail index forward. The engine walks the ring from its own head index up to the tail. It reads each command as two 64-bit words over a simple memory read port and carries it out. It then steps the head, wrapping at the end of the ring.

Two command kinds are understood. A cache-entry invalidation command finishes with no side effect, because the cache it targets lives outside this block. A wait command can post a 32-bit status word to memory, and it can pulse a completion event. Any other command kind is a queue error. The engine sets a sticky error flag, leaves the head on the bad command and fetches nothing more until software clears the flag through a fault-status write. Illegal writes to the queue-address or tail register are dropped without any effect.

Top module: `inv_queue_engine`

## Requirements
- R1: After reset the queue address, head and tail read as zero, the error flag and busy are low, and no memory request is active.
- R2: A queue-address write is dropped if any of bits 11:3 is set, or any bit at or above GAW is set. Otherwise it is stored: bits 63:12 give the ring base and bits 2:0 give the size code QS.
- R3: A tail write is dropped if it sets any bit outside 18:4, or if its index (bits 18:4) is not below 2^(ENTRY_ORDER+QS).
- R4: While the head index equals the tail index, no memory read is issued.
- R5: Command number i is read as its low word at base+16*i and then its high word at base+16*i+8. The kind is in low-word bits 3:0. Kind 4 (cache invalidation) completes with no write and no event, and the head advances by one.
- R6: Kind 5 (wait) with low-word bit 5 set writes low-word bits 63:32 to address {high[63:2],2'b00} before the head advances.
- R7: Kind 5 with low-word bit 4 set drives wait_done_o high for exactly one cycle when the command completes.
- R8: Any other kind sets the error flag, leaves the head on that command, and stops all further reads while the flag stays set.
- R9: A fault-status write with bit 4 set clears the error flag, and processing resumes at the head.
- R10: The head index wraps to zero after entry 2^(ENTRY_ORDER+QS)-1.
- R11: busy_o is high exactly while the head differs from the tail and the error flag is clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| iqa_we_i | input | 1 | Queue-address register write strobe |
| iqa_wdata_i | input | 64 | Queue-address write data |
| iqt_we_i | input | 1 | Tail register write strobe |
| iqt_wdata_i | input | 64 | Tail write data |
| fsts_we_i | input | 1 | Fault-status write strobe |
| fsts_wdata_i | input | 32 | Fault-status write data, bit 4 clears the error flag |
| rd_req_o | output | 1 | Memory read request, held until accepted |
| rd_addr_o | output | 64 | Memory read byte address |
| rd_valid_i | input | 1 | Read data valid, accepts the request |
| rd_data_i | input | 64 | Read data |
| wr_req_o | output | 1 | Status write request, held until accepted |
| wr_addr_o | output | 64 | Status write byte address |
| wr_data_o | output | 32 | Status write data |
| wr_ready_i | input | 1 | Status write accepted |
| iqa_o | output | 64 | Current queue-address register |
| iqh_o | output | 64 | Head register, index in bits 18:4 |
| iqt_o | output | 64 | Tail register, index in bits 18:4 |
| iqe_o | output | 1 | Sticky queue-error flag |
| busy_o | output | 1 | Commands pending and no error |
| wait_done_o | output | 1 | One-cycle completion event pulse |

## Verification
The engine is driven with a sequence of single commands of every flag mix: cache invalidation, wait with no flags, status only, event only, both together, and two unknown kinds. Comparing write and event counts between these cases separates the effect of each flag from the command kind. Half the commands run with a read port that stalls every other cycle, which shows the fetch holds its address and does not lose a word. A long run up to the last ring entry followed by a short tail past zero shows the wrap. Tail and address writes with reserved bits, or with an index past the ring size, must leave the registers as they were. The same tail index must be refused at the smallest size code and accepted once the ring is made larger.

// File: rtl/invq_pkg.sv
package invq_pkg;
  localparam int IDX_LSB = 4;
  localparam int IDX_MSB = 18;
  localparam int IDX_W   = IDX_MSB - IDX_LSB + 1;
  localparam int ERR_BIT = 4;
  localparam int FL_EVT  = 4;
  localparam int FL_STAT = 5;
  localparam logic [3:0] KIND_IEC  = 4'h4;
  localparam logic [3:0] KIND_WAIT = 4'h5;

  typedef enum logic [2:0] {
    S_IDLE, S_RD_LO, S_RD_HI, S_EXEC, S_WR
  } fsm_e;
endpackage

// File: rtl/invq_regs.sv
module invq_regs
  import invq_pkg::*;
#(
  parameter int ENTRY_ORDER = 8,
  parameter int GAW         = 48
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             iqa_we_i,
  input  logic [63:0]      iqa_wdata_i,
  input  logic             iqt_we_i,
  input  logic [63:0]      iqt_wdata_i,
  input  logic             fsts_we_i,
  input  logic [31:0]      fsts_wdata_i,
  input  logic             err_set_i,
  output logic [63:0]      iqa_o,
  output logic [IDX_W-1:0] tail_o,
  output logic [IDX_W-1:0] idx_mask_o,
  output logic             iqe_o
);
  localparam logic [63:0] HI_MASK   = (GAW >= 64) ? 64'd0 : ~((64'd1 << GAW) - 64'd1);
  localparam logic [63:0] IDX_FIELD = ((64'd1 << IDX_W) - 64'd1) << IDX_LSB;

  logic [63:0]      iqa_q;
  logic [IDX_W-1:0] tail_q;
  logic             iqe_q;
  logic [IDX_W:0]   ent;
  logic [IDX_W-1:0] wr_idx;
  logic             iqa_ok, tail_ok;

  assign ent        = {{IDX_W{1'b0}}, 1'b1} << (ENTRY_ORDER + int'(iqa_q[2:0]));
  assign idx_mask_o = IDX_W'(ent - 1'b1);
  assign wr_idx     = iqt_wdata_i[IDX_MSB:IDX_LSB];

  assign iqa_ok  = (iqa_wdata_i[11:3] == '0) && ((iqa_wdata_i & HI_MASK) == '0);
  assign tail_ok = ((iqt_wdata_i & ~IDX_FIELD) == '0) && ((wr_idx & ~idx_mask_o) == '0);

  wire unused_fsts = ^{fsts_wdata_i[31:ERR_BIT+1], fsts_wdata_i[ERR_BIT-1:0]};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      iqa_q  <= '0;
      tail_q <= '0;
      iqe_q  <= 1'b0;
    end else begin
      if (iqa_we_i && iqa_ok) iqa_q <= iqa_wdata_i;
      if (iqt_we_i && tail_ok) tail_q <= wr_idx;
      if (err_set_i) iqe_q <= 1'b1;
      else if (fsts_we_i && fsts_wdata_i[ERR_BIT]) iqe_q <= 1'b0;
    end
  end

  assign iqa_o  = iqa_q;
  assign tail_o = tail_q;
  assign iqe_o  = iqe_q;

  AST_IQA_RSVD_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    iqa_q[11:3] == '0); // R2
  AST_TAIL_RSVD_DROP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (iqt_we_i && iqt_wdata_i[0]) |=> $stable(tail_q)); // R3
  AST_ERR_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (iqe_q && !fsts_we_i) |=> iqe_q); // R9
endmodule

// File: rtl/invq_fetch.sv
module invq_fetch
  import invq_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [51:0]      base_i,
  input  logic [IDX_W-1:0] tail_i,
  input  logic [IDX_W-1:0] idx_mask_i,
  input  logic             iqe_i,
  output logic             rd_req_o,
  output logic [63:0]      rd_addr_o,
  input  logic             rd_valid_i,
  input  logic [63:0]      rd_data_i,
  output logic             wr_req_o,
  output logic [63:0]      wr_addr_o,
  output logic [31:0]      wr_data_o,
  input  logic             wr_ready_i,
  output logic [IDX_W-1:0] head_o,
  output logic             err_set_o,
  output logic             evt_o
);
  fsm_e             state_q, state_d;
  logic [63:0]      lo_q, hi_q;
  logic [IDX_W-1:0] head_q;
  logic             evt_q;
  logic             is_iec, is_wait, complete;

  assign is_iec  = lo_q[3:0] == KIND_IEC;
  assign is_wait = lo_q[3:0] == KIND_WAIT;

  assign complete  = (state_q == S_EXEC && (is_iec || (is_wait && !lo_q[FL_STAT])))
                   || (state_q == S_WR && wr_ready_i);
  assign err_set_o = (state_q == S_EXEC) && !is_iec && !is_wait;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      S_IDLE:  if (!iqe_i && head_q != tail_i) state_d = S_RD_LO;
      S_RD_LO: if (rd_valid_i) state_d = S_RD_HI;
      S_RD_HI: if (rd_valid_i) state_d = S_EXEC;
      S_EXEC:  state_d = (is_wait && lo_q[FL_STAT]) ? S_WR : S_IDLE;
      S_WR:    if (wr_ready_i) state_d = S_IDLE;
      default: state_d = S_IDLE;
    endcase
  end

  assign rd_req_o  = (state_q == S_RD_LO) || (state_q == S_RD_HI);
  assign rd_addr_o = {base_i, 12'h000} + (64'(head_q) << IDX_LSB)
                   + ((state_q == S_RD_HI) ? 64'd8 : 64'd0);
  assign wr_req_o  = state_q == S_WR;
  assign wr_addr_o = {hi_q[63:2], 2'b00};
  assign wr_data_o = lo_q[63:32];

  wire unused_desc = ^{lo_q[31:FL_STAT+1], hi_q[1:0]};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= S_IDLE;
      lo_q    <= '0;
      hi_q    <= '0;
      head_q  <= '0;
      evt_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      if (state_q == S_RD_LO && rd_valid_i) lo_q <= rd_data_i;
      if (state_q == S_RD_HI && rd_valid_i) hi_q <= rd_data_i;
      if (complete) head_q <= (head_q + 1'b1) & idx_mask_i;
      evt_q <= complete && is_wait && lo_q[FL_EVT];
    end
  end

  assign head_o = head_q;
  assign evt_o  = evt_q;

  AST_NO_FETCH_ON_ERR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    iqe_i |-> !rd_req_o); // R8
  AST_ERR_HOLDS_HEAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(iqe_i) |-> $stable(head_q)); // R8
  AST_HEAD_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(head_q) |-> head_q == (($past(head_q) + 1'b1) & $past(idx_mask_i))); // R10
  AST_EMPTY_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == S_IDLE && head_q == tail_i) |=> !rd_req_o); // R4
  AST_EVT_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    evt_q |=> !evt_q); // R7
endmodule

// File: rtl/inv_queue_engine.sv
module inv_queue_engine
  import invq_pkg::*;
#(
  parameter int ENTRY_ORDER = 8,
  parameter int GAW         = 48
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        iqa_we_i,
  input  logic [63:0] iqa_wdata_i,
  input  logic        iqt_we_i,
  input  logic [63:0] iqt_wdata_i,
  input  logic        fsts_we_i,
  input  logic [31:0] fsts_wdata_i,
  output logic        rd_req_o,
  output logic [63:0] rd_addr_o,
  input  logic        rd_valid_i,
  input  logic [63:0] rd_data_i,
  output logic        wr_req_o,
  output logic [63:0] wr_addr_o,
  output logic [31:0] wr_data_o,
  input  logic        wr_ready_i,
  output logic [63:0] iqa_o,
  output logic [63:0] iqh_o,
  output logic [63:0] iqt_o,
  output logic        iqe_o,
  output logic        busy_o,
  output logic        wait_done_o
);
  logic [IDX_W-1:0] tail, head, idx_mask;
  logic             iqe, err_set;
  logic [63:0]      iqa;

  invq_regs #(.ENTRY_ORDER(ENTRY_ORDER), .GAW(GAW)) regs_i (
    .clk_i, .rst_ni,
    .iqa_we_i, .iqa_wdata_i, .iqt_we_i, .iqt_wdata_i, .fsts_we_i, .fsts_wdata_i,
    .err_set_i (err_set),
    .iqa_o     (iqa),
    .tail_o    (tail),
    .idx_mask_o(idx_mask),
    .iqe_o     (iqe)
  );

  invq_fetch fetch_i (
    .clk_i, .rst_ni,
    .base_i    (iqa[63:12]),
    .tail_i    (tail),
    .idx_mask_i(idx_mask),
    .iqe_i     (iqe),
    .rd_req_o, .rd_addr_o, .rd_valid_i, .rd_data_i,
    .wr_req_o, .wr_addr_o, .wr_data_o, .wr_ready_i,
    .head_o    (head),
    .err_set_o (err_set),
    .evt_o     (wait_done_o)
  );

  assign iqa_o  = iqa;
  assign iqh_o  = 64'(head) << IDX_LSB;
  assign iqt_o  = 64'(tail) << IDX_LSB;
  assign iqe_o  = iqe;
  assign busy_o = (head != tail) && !iqe;

  AST_BUSY_NO_WRITE_ON_ERR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    iqe |-> !wr_req_o); // R8
endmodule

// File: tb/inv_queue_engine_tb_top.sv
`timescale 1ns/1ps
module inv_queue_engine_tb_top;
  localparam logic [63:0] BASE = 64'h0000_0000_0010_0000;
  localparam logic [63:0] IEC  = 64'h4;

  typedef struct packed {
    logic [63:0] lo;
    logic [63:0] hi;
    logic        wr;
    logic        evt;
    logic        err;
  } vec_t;

  localparam vec_t VECS [7] = '{
    '{64'h0000_0000_0000_0004, 64'h0,                  1'b0, 1'b0, 1'b0},
    '{64'hCAFE_0001_0000_0025, 64'h0000_0000_0002_0043, 1'b1, 1'b0, 1'b0},
    '{64'h0000_0000_0000_0015, 64'h0,                  1'b0, 1'b1, 1'b0},
    '{64'h1234_5678_0000_0035, 64'h0000_0000_0003_0000, 1'b1, 1'b1, 1'b0},
    '{64'h0000_0000_0000_0005, 64'h0,                  1'b0, 1'b0, 1'b0},
    '{64'h0000_0000_0000_0037, 64'h0,                  1'b0, 1'b0, 1'b1},
    '{64'h0000_0000_0000_0000, 64'h0,                  1'b0, 1'b0, 1'b1}
  };

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        iqa_we_i = 1'b0, iqt_we_i = 1'b0, fsts_we_i = 1'b0;
  logic [63:0] iqa_wdata_i = '0, iqt_wdata_i = '0;
  logic [31:0] fsts_wdata_i = '0;
  logic        rd_req_o, rd_valid_i, wr_req_o, busy_o, iqe_o, wait_done_o;
  logic [63:0] rd_addr_o, rd_data_i, wr_addr_o, iqa_o, iqh_o, iqt_o;
  logic [31:0] wr_data_o;
  logic        wr_ready_i = 1'b1;

  logic [63:0] mem [0:1023];
  logic [63:0] rd_off;
  logic        stall = 1'b0, stall_en = 1'b0;
  int          rd_cnt = 0, wr_cnt = 0, evt_cnt = 0;
  logic [63:0] rd_last = '0, rd_prev = '0, wr_last_addr = '0;
  logic [31:0] wr_last_data = '0;
  int          n_chk = 0, n_err = 0, cyc = 0;

  always #4 clk = ~clk;

  inv_queue_engine dut_i (
    .clk_i(clk), .rst_ni,
    .iqa_we_i, .iqa_wdata_i, .iqt_we_i, .iqt_wdata_i, .fsts_we_i, .fsts_wdata_i,
    .rd_req_o, .rd_addr_o, .rd_valid_i, .rd_data_i,
    .wr_req_o, .wr_addr_o, .wr_data_o, .wr_ready_i,
    .iqa_o, .iqh_o, .iqt_o, .iqe_o, .busy_o, .wait_done_o
  );

  assign rd_off     = rd_addr_o - BASE;
  assign rd_valid_i = rd_req_o && !stall;
  assign rd_data_i  = (rd_off < 64'd8192) ? mem[rd_off[12:3]] : 64'h0;

  always @(posedge clk) stall <= stall_en ? ~stall : 1'b0;

  always @(negedge clk) begin
    if (rd_req_o && rd_valid_i) begin
      rd_cnt  <= rd_cnt + 1;
      rd_prev <= rd_last;
      rd_last <= rd_addr_o;
    end
    if (wr_req_o && wr_ready_i) begin
      wr_cnt       <= wr_cnt + 1;
      wr_last_addr <= wr_addr_o;
      wr_last_data <= wr_data_o;
    end
    if (wait_done_o) evt_cnt <= evt_cnt + 1;
  end

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == 150000) begin
      n_err = n_err + 1;
      n_chk = n_chk + 1;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk = n_chk + 1;
    if (act !== exp) begin
      n_err = n_err + 1;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr_iqa(input logic [63:0] d);
    @(negedge clk); iqa_we_i = 1'b1; iqa_wdata_i = d;
    @(negedge clk); iqa_we_i = 1'b0;
  endtask

  task automatic wr_tail(input logic [63:0] d);
    @(negedge clk); iqt_we_i = 1'b1; iqt_wdata_i = d;
    @(negedge clk); iqt_we_i = 1'b0;
  endtask

  task automatic wr_fsts(input logic [31:0] d);
    @(negedge clk); fsts_we_i = 1'b1; fsts_wdata_i = d;
    @(negedge clk); fsts_we_i = 1'b0;
  endtask

  task automatic wait_idle();
    for (int k = 0; k < 20000 && busy_o; k++) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  initial begin
    int h, rd0, wr0, ev0;
    for (int i = 0; i < 1024; i++) mem[i] = (i % 2 == 0) ? IEC : 64'h0;
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 iqa", iqa_o, 64'h0);
    check("R1 head", iqh_o, 64'h0);
    check("R1 tail", iqt_o, 64'h0);
    check("R1 iqe", 64'(iqe_o), 64'h0);
    check("R1 busy", 64'(busy_o), 64'h0);
    check("R1 rd_req", 64'(rd_req_o), 64'h0);
    rst_ni = 1'b1;
    @(negedge clk);

    // R2 address register validation
    wr_iqa(BASE | 64'h8);
    check("R2 rsvd bit3 dropped", iqa_o, 64'h0);
    wr_iqa(BASE | (64'd1 << 48));
    check("R2 bit GAW dropped", iqa_o, 64'h0);
    wr_iqa(BASE);
    check("R2 legal write", iqa_o, BASE);

    // R4 empty ring
    rd0 = rd_cnt;
    repeat (20) @(negedge clk);
    check("R4 no read when empty", 64'(rd_cnt - rd0), 64'h0);
    check("R4 busy low when empty", 64'(busy_o), 64'h0);

    // R3 tail validation at QS=0
    wr_tail(64'h11);
    check("R3 tail rsvd dropped", iqt_o, 64'h0);
    wr_tail(64'd256 << 4);
    check("R3 tail idx 256 dropped QS0", iqt_o, 64'h0);
    check("R3 nothing fetched", 64'(rd_cnt - rd0), 64'h0);

    // table walk
    h = 0;
    for (int v = 0; v < 7; v++) begin
      mem[2*h]     = VECS[v].lo;
      mem[2*h + 1] = VECS[v].hi;
      stall_en = v[0];
      rd0 = rd_cnt; wr0 = wr_cnt; ev0 = evt_cnt;
      wr_tail(64'((h + 1) % 256) << 4);
      check("R11 busy while pending", 64'(busy_o), 64'h1);
      wait_idle();
      check("R5 low word addr", rd_prev, BASE + 64'(16 * h));
      check("R5 high word addr", rd_last, BASE + 64'(16 * h) + 64'd8);
      check("R6 status writes", 64'(wr_cnt - wr0), 64'(VECS[v].wr));
      if (VECS[v].wr) begin
        check("R6 status addr", wr_last_addr, {VECS[v].hi[63:2], 2'b00});
        check("R6 status data", 64'(wr_last_data), 64'(VECS[v].lo[63:32]));
      end
      check("R7 events", 64'(evt_cnt - ev0), 64'(VECS[v].evt));
      check("R8 error flag", 64'(iqe_o), 64'(VECS[v].err));
      if (VECS[v].err) begin
        check("R8 head held", iqh_o, 64'(h) << 4);
        rd0 = rd_cnt;
        repeat (20) @(negedge clk);
        check("R8 no fetch while error", 64'(rd_cnt - rd0), 64'h0);
        check("R11 busy low on error", 64'(busy_o), 64'h0);
        mem[2*h] = IEC;
        wr_fsts(32'h10);
        wait_idle();
        check("R9 error cleared", 64'(iqe_o), 64'h0);
        check("R9 resumed", iqh_o, 64'((h + 1) % 256) << 4);
      end else begin
        check("R5 head advanced", iqh_o, 64'((h + 1) % 256) << 4);
      end
      mem[2*h] = IEC; mem[2*h + 1] = 64'h0;
      h = (h + 1) % 256;
    end
    stall_en = 1'b0;

    // R10 wrap
    wr_tail(64'd255 << 4);
    wait_idle();
    check("R10 head at last entry", iqh_o, 64'd255 << 4);
    rd0 = rd_cnt;
    wr_tail(64'd2 << 4);
    wait_idle();
    check("R10 head wrapped", iqh_o, 64'd2 << 4);
    check("R10 three commands read", 64'(rd_cnt - rd0), 64'd6);

    // R3 larger ring accepts index 256
    wr_iqa(BASE | 64'h1);
    check("R2 qs stored", iqa_o, BASE | 64'h1);
    wr_tail(64'd256 << 4);
    check("R3 tail idx 256 accepted QS1", iqt_o, 64'd256 << 4);
    wait_idle();
    check("R11 drained", 64'(busy_o), 64'h0);

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule